// File: doc/BRIEF.md
# Sequential Delay Line with One-Hot Ring Addressing

This block delays a stream of samples by a fixed number of accepted samples. Storage is a bank of registers, one word per delay position. A circulating one-hot token selects the word to use, so the block needs no binary address decoder. Each word's write strobe is one bit of the token. The word the token points at holds the oldest sample. That word is read out in the same step that it is overwritten with the new input.

The token register is cut into equal groups. Each group updates its token bits only under its own group enable, and that enable is derived from the token itself: a group is enabled when it holds the token, and also when the token sits on the position just before the group, so the group is ready one step before the token enters it. A second, per-group word-select drives the storage banks. Only the bank that holds the active position receives the write data and puts a value on the shared read path. The other banks see zeros and drive zeros.

The input carries a valid flag. Steps without a valid input leave the token, the storage and the fill state untouched. The output is registered and is valid only on the cycle that follows an accepted input, once the line has filled.

Top module: `ring_delay_line`

## Requirements
- R1: While `rst` is high on a clock edge, the block clears `out_valid` and places the token at position 0. The first sample accepted after reset therefore selects group 0. `err` is low after reset.
- R2: `out_valid` is high on the cycle after an accepted input only when at least DEPTH samples were accepted before that input since reset. In every other cycle it is low.
- R3: When `out_valid` is high, `out_data` equals the sample accepted exactly DEPTH accepted samples before the input of the previous cycle. Samples leave in the order in which they arrived.
- R4: A cycle with `in_valid` low changes no stored word, token position or fill state. In such a cycle `grp_sel` is all zeros, and `out_valid` is low in the next cycle.
- R5: In a cycle with `in_valid` high, `grp_sel` has exactly one bit set. That bit is at index floor(p / GSIZE), where p is the number of samples accepted since reset, taken modulo DEPTH. Bit i of `grp_sel` belongs to words i*GSIZE through i*GSIZE+GSIZE-1.
- R6: The token holds exactly one set bit at all times after reset. `err` goes high in any cycle where it does not.
- R7: The token wraps from position DEPTH-1 back to position 0. Delay and group selection stay correct over many revolutions of the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | WIDTH | Input sample |
| out_valid | output | 1 | Delayed sample present |
| out_data | output | WIDTH | Delayed sample |
| grp_sel | output | DEPTH/GSIZE | Per-group storage enable for the current step |
| err | output | 1 | Token is not one-hot |

## Verification
`grp_sel` and `err` are combinational from the current inputs and the token. The bench therefore reads them after it drives the inputs and before the next rising edge. `out_valid` and `out_data` pass through one register, so they are due one cycle after the input that produced them. The bench samples them 1 ns after that edge. A behavioural queue and an acceptance counter give the expected values for every cycle, including idle ones, across several wraps of the ring and a second reset in the middle of the run.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

    // Per-step control derived from the input handshake and the ring state
    typedef struct packed {
        logic accept;   // a sample is taken this cycle
        logic wrap;     // the token sits at the last position
    } step_t;

    function automatic int unsigned group_count(input int unsigned depth,
                                                input int unsigned gsize);
        return depth / gsize;
    endfunction

    // Ring position that precedes a given position
    function automatic int unsigned prev_pos(input int unsigned pos,
                                             input int unsigned depth);
        return (pos + depth - 1) % depth;
    endfunction

endpackage

// File: rtl/rdl_ring.sv
module rdl_ring #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned GSIZE  = 4,
    localparam int unsigned NGROUP = rdl_pkg::group_count(DEPTH, GSIZE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [DEPTH-1:0]  token,
    output logic [NGROUP-1:0] grp_sel
);
    localparam logic [DEPTH-1:0] TOKEN_INIT = DEPTH'(1);

    logic [DEPTH-1:0]  token_nx;
    logic [NGROUP-1:0] ring_en;

    assign token_nx = {token[DEPTH-2:0], token[DEPTH-1]};

    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        localparam int unsigned LO   = g * GSIZE;
        localparam int unsigned PREV = rdl_pkg::prev_pos(LO, DEPTH);

        logic holds;
        assign holds = |token[LO +: GSIZE];

        // enabled while holding the token, or one step before it arrives
        assign ring_en[g] = advance & (holds | token[PREV]);
        assign grp_sel[g] = advance & holds;

        always_ff @(posedge clk) begin
            if (rst)
                token[LO +: GSIZE] <= TOKEN_INIT[LO +: GSIZE];
            else if (ring_en[g])
                token[LO +: GSIZE] <= token_nx[LO +: GSIZE];
        end
    end

    // R6: token stays one-hot
    a_r6_token_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot(token));

    // R4: idle steps leave the token where it is
    a_r4_token_hold: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(token));

    // R4: idle steps select no group
    a_r4_idle_no_sel: assert property (@(posedge clk) disable iff (rst)
        !advance |-> (grp_sel == '0));

    // R5: an accepted step selects exactly one group
    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        advance |-> $onehot(grp_sel));

    // R7: the token always moves to the next position on an accepted step
    a_r7_token_moves: assert property (@(posedge clk) disable iff (rst)
        advance |=> (token == {$past(token[DEPTH-2:0]), $past(token[DEPTH-1])}));

endmodule

// File: rtl/rdl_bank.sv
module rdl_bank #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned GSIZE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic [GSIZE-1:0] wsel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [GSIZE-1:0][WIDTH-1:0] words;
    logic [WIDTH-1:0]            local_wdata;
    logic [WIDTH-1:0]            local_rd;

    // only a selected bank sees the write data
    assign local_wdata = sel ? wdata : '0;

    for (genvar w = 0; w < GSIZE; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (sel && wsel[w])
                words[w] <= local_wdata;
        end
    end

    always_comb begin
        local_rd = '0;
        for (int w = 0; w < GSIZE; w++)
            if (wsel[w])
                local_rd = local_rd | words[w];
    end

    // only a selected bank drives the read path
    assign rdata = sel ? local_rd : '0;

    // R4: an unselected bank keeps its contents
    a_r4_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(words));

    // R5: an unselected bank drives nothing
    a_r5_bank_quiet: assert property (@(posedge clk) disable iff (rst)
        !sel |-> (rdata == '0));

endmodule

// File: rtl/ring_delay_line.sv
module ring_delay_line #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned GSIZE  = 4,
    localparam int unsigned NGROUP = rdl_pkg::group_count(DEPTH, GSIZE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WIDTH-1:0]  in_data,
    output logic              out_valid,
    output logic [WIDTH-1:0]  out_data,
    output logic [NGROUP-1:0] grp_sel,
    output logic              err
);
    rdl_pkg::step_t   step;
    logic [DEPTH-1:0] token;
    logic             filled;
    logic [WIDTH-1:0] bank_rd [NGROUP];
    logic [WIDTH-1:0] rd_word;

    rdl_ring #(.DEPTH(DEPTH), .GSIZE(GSIZE)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .advance (in_valid),
        .token   (token),
        .grp_sel (grp_sel)
    );

    for (genvar g = 0; g < NGROUP; g++) begin : g_bank
        rdl_bank #(.WIDTH(WIDTH), .GSIZE(GSIZE)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .sel   (grp_sel[g]),
            .wsel  (token[g*GSIZE +: GSIZE]),
            .wdata (in_data),
            .rdata (bank_rd[g])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int g = 0; g < NGROUP; g++)
            rd_word = rd_word | bank_rd[g];
    end

    assign step.accept = in_valid;
    assign step.wrap   = token[DEPTH-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            filled    <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (step.accept && step.wrap)
                filled <= 1'b1;
            out_valid <= step.accept && filled;
            if (step.accept)
                out_data <= rd_word;
        end
    end

    assign err = ($countones(token) != 1);

    // R2: a valid output always follows an accepted input
    a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R6: the error flag stays low on a sound ring
    a_r6_no_error: assert property (@(posedge clk) disable iff (rst)
        !err);

    // R4: the fill state does not move on idle steps
    a_r4_fill_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(filled));

endmodule

// File: tb/sim_ring_delay_line.sv
module sim_ring_delay_line;
    localparam int WIDTH  = 8;
    localparam int DEPTH  = 16;
    localparam int GSIZE  = 4;
    localparam int NGROUP = DEPTH / GSIZE;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [WIDTH-1:0]  in_data = '0;
    logic              out_valid;
    logic [WIDTH-1:0]  out_data;
    logic [NGROUP-1:0] grp_sel;
    logic              err;

    int checks = 0;
    int fails  = 0;
    int accepted = 0;
    logic [WIDTH-1:0] ref_q [$];
    int unsigned seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    ring_delay_line #(.WIDTH(WIDTH), .DEPTH(DEPTH), .GSIZE(GSIZE)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .grp_sel(grp_sel), .err(err)
    );

    task automatic check(input string req, input logic ok,
                         input int actual, input int expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        check("R1 out_valid after reset", out_valid == 1'b0, out_valid, 0);
        check("R1 err after reset", err == 1'b0, err, 0);
        @(negedge clk);
        rst = 1'b0;
        accepted = 0;
        ref_q.delete();
    endtask

    // one cycle: drive, check comb outputs, clock, check registered outputs
    task automatic step(input logic v, input logic [WIDTH-1:0] d);
        logic [NGROUP-1:0] exp_sel;
        logic              exp_valid;
        logic [WIDTH-1:0]  exp_data;
        @(negedge clk);
        in_valid = v; in_data = d;
        #0.5;
        exp_sel = '0;
        if (v) exp_sel[(accepted % DEPTH) / GSIZE] = 1'b1;
        if (v) check("R5 grp_sel on accepted step", grp_sel == exp_sel, grp_sel, exp_sel);
        else   check("R4 grp_sel idle", grp_sel == '0, grp_sel, 0);
        check("R6 err low", err == 1'b0, err, 0);
        exp_valid = 1'b0; exp_data = '0;
        if (v) begin
            ref_q.push_back(d);
            accepted++;
            if (ref_q.size() > DEPTH) begin
                exp_valid = 1'b1;
                exp_data  = ref_q.pop_front();
            end
        end
        @(posedge clk);
        #1;
        if (v) check("R2 out_valid after accept", out_valid == exp_valid, out_valid, exp_valid);
        else   check("R4 out_valid after idle", out_valid == 1'b0, out_valid, 0);
        if (exp_valid)
            check("R3 delayed data", out_data == exp_data, out_data, exp_data);
    endtask

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: first accepted sample lands in group 0 (checked inside step)
        // R2/R3: fill with back-to-back input, then stream
        for (int i = 0; i < 3 * DEPTH; i++) step(1'b1, WIDTH'(i * 7 + 3));
        // R4: long idle gap, then stream must resume from stored state
        for (int i = 0; i < 10; i++) step(1'b0, 8'hA5);
        for (int i = 0; i < DEPTH; i++) step(1'b1, WIDTH'(i ^ 8'h5A));
        // R7: random gaps over many revolutions
        for (int i = 0; i < 400; i++) step((rnd() % 3) != 0, WIDTH'(rnd()));
        // R1: reset in the middle, refill must restart
        do_reset();
        for (int i = 0; i < DEPTH + 8; i++) step(1'b1, WIDTH'(200 - i));
        for (int i = 0; i < 200; i++) step((rnd() % 2) != 0, WIDTH'(rnd()));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule